// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is a bus-master DMA engine. It walks a table of two-word descriptors held in system memory and moves data between a device-side stream and memory buffers. Software writes the table base address, then sets the direction and the go bit in the control register. The engine fetches each descriptor in turn and transfers its segment one 32-bit word at a time. It finishes after the segment whose descriptor carries the end-of-table mark.

The block has three interfaces. A small register port holds control, status and the table base. A single memory master port carries reads and writes and waits on a ready handshake. Two device streams use valid/ready: one delivers data towards memory, the other takes data from memory. A stop bit ends a running transfer at once. A hold bit keeps the engine parked. Bad segment lengths are reported as an error and are never transferred.

Top module: `sgdma_engine`

## Requirements
- R1: Descriptor k sits at table base + 8*k. The base register keeps address bits [31:3] and reads [2:0] as zero. Word 0 holds the buffer address and word 1[28:0] the byte length. A segment moves ceil(length/4) words at the address with bits [1:0] cleared, stepping by 4.
- R2: With control bit 11 set, the end-of-table mark is word 0 bit 0. With bit 11 clear, the mark is word 1 bit 31.
- R3: Control bit 2 set means device-to-memory: words from the input stream become memory writes, and a final partial word enables only its low byte lanes (byte enable bit i covers data bits 8i+7:8i). Bit 2 clear means memory-to-device: each read word is offered on the output stream.
- R4: After the final word of the end-of-table segment, status bit 0 (active) drops, status bit 1 (normal end) is set and control bit 0 (start) reads 0.
- R5: A zero-length descriptor causes no access to its buffer. The walk then continues with the next descriptor, or ends normally if this descriptor carries the mark.
- R6: A length above 0x1FFFFFFE sets status bit 2 (error) and ends the walk with no data transfer, no normal end and start cleared. A length of exactly 0x1FFFFFFE is accepted.
- R7: Writing control with bit 1 (stop) set while start is set terminates the walk in that cycle. No further handshake occurs, start and active clear, and normal end stays clear.
- R8: While control bit 7 (hold) is set, start cannot be set. Setting hold during a walk aborts it and clears normal end and error.
- R9: Status bits 1, 2 and 4 are cleared by writing 1 to them. Writing 0 leaves them unchanged, and writes to bit 0 have no effect.
- R10: A high dev_irq input sets status bit 4.
- R11: After reset, control, status and base read 0 and no memory request is made. Register selects are 0 for control, 1 for status and 2 for base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| dev_irq | input | 1 | Device interrupt event |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ready | input | 1 | Memory accepts request (read data valid in the same cycle) |
| mem_rdata | input | 32 | Memory read data |
| in_valid | input | 1 | Device-to-memory word valid |
| in_ready | output | 1 | Device-to-memory word taken |
| in_data | input | 32 | Device-to-memory word |
| out_valid | output | 1 | Memory-to-device word valid |
| out_ready | input | 1 | Memory-to-device word accepted |
| out_data | output | 32 | Memory-to-device word |

## Verification
The bench targets the following corner cases:
- A length that is not a multiple of four. If the rounding were wrong, the engine would drop the last word or write a full word over the bytes that follow.
- A zero-length descriptor, with or without the end mark. An engine that touched its buffer or stalled would show up as hits in a watched address range or as a walk that never finishes.
- The two end-mark positions. A swapped decode would stop after the first descriptor, or run on past the last.
- The length limit and its neighbour. 0x1FFFFFFF must raise the error with no data moved, while 0x1FFFFFFE must run.
- Stop and hold against a stalled walk. A late abort would let a word slip out after the termination.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int LEN_W   = 29;
    localparam logic [LEN_W-1:0] SEG_MAX = 29'h1FFF_FFFE;
    localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(BE_W);

    // control bit positions
    localparam int C_GO    = 0;
    localparam int C_STOP  = 1;
    localparam int C_TOMEM = 2;
    localparam int C_HOLD  = 7;
    localparam int C_FLAG0 = 11;

    // status bit positions
    localparam int S_ACT   = 0;
    localparam int S_END   = 1;
    localparam int S_ERR   = 2;
    localparam int S_DEV   = 4;

    // register selects
    localparam int SEL_CTRL = 0;
    localparam int SEL_STAT = 1;
    localparam int SEL_BASE = 2;

    typedef struct packed {
        logic hold;
        logic flag_in_addr;
        logic to_mem;
        logic go;
    } ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              last;
    } desc_t;

    typedef enum logic [2:0] {
        W_IDLE,
        W_FETCH_A,
        W_FETCH_L,
        W_MOVE,
        W_PUSH
    } wstate_t;

    function automatic desc_t decode_desc(input logic [DATA_W-1:0] w0,
                                          input logic [DATA_W-1:0] w1,
                                          input logic flag_in_addr);
        desc_t d;
        d.addr = {w0[ADDR_W-1:2], 2'b00};
        d.len  = w1[LEN_W-1:0];
        d.last = flag_in_addr ? w0[0] : w1[DATA_W-1];
        return d;
    endfunction

    function automatic logic [BE_W-1:0] lane_mask(input logic [LEN_W-1:0] left);
        logic [BE_W-1:0] m;
        for (int i = 0; i < BE_W; i++)
            m[i] = (left > LEN_W'(i));
        return m;
    endfunction

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
    import sgdma_pkg::*;
#(
    parameter int REG_AW = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                dev_irq,
    input  logic                busy,
    input  logic                ev_end,
    input  logic                ev_err,
    output ctrl_t               ctrl,
    output logic [ADDR_W-1:0]   base,
    output logic                kill
);

    logic wr_ctrl, wr_stat, wr_base;
    logic st_end, st_err, st_dev;
    logic [ADDR_W-1:3] base_q;

    assign wr_ctrl = reg_we && (reg_addr == REG_AW'(SEL_CTRL));
    assign wr_stat = reg_we && (reg_addr == REG_AW'(SEL_STAT));
    assign wr_base = reg_we && (reg_addr == REG_AW'(SEL_BASE));

    // stop or hold written while running aborts the walk in this cycle
    assign kill = wr_ctrl && ctrl.go && (reg_wdata[C_STOP] || reg_wdata[C_HOLD]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            base_q <= '0;
            st_end <= 1'b0;
            st_err <= 1'b0;
            st_dev <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.to_mem       <= reg_wdata[C_TOMEM];
                ctrl.flag_in_addr <= reg_wdata[C_FLAG0];
                ctrl.hold         <= reg_wdata[C_HOLD];
            end
            if (wr_ctrl && (reg_wdata[C_STOP] || reg_wdata[C_HOLD]))
                ctrl.go <= 1'b0;
            else if (ev_end || ev_err)
                ctrl.go <= 1'b0;
            else if (wr_ctrl && reg_wdata[C_GO])
                ctrl.go <= 1'b1;

            if (wr_base)
                base_q <= reg_wdata[ADDR_W-1:3];

            if (ctrl.hold) begin
                st_end <= 1'b0;
                st_err <= 1'b0;
            end else begin
                st_end <= (st_end && !(wr_stat && reg_wdata[S_END])) || ev_end;
                st_err <= (st_err && !(wr_stat && reg_wdata[S_ERR])) || ev_err;
            end
            st_dev <= (st_dev && !(wr_stat && reg_wdata[S_DEV])) || dev_irq;
        end
    end

    assign base = {base_q, 3'b000};

    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            SEL_CTRL: begin
                reg_rdata[C_GO]    = ctrl.go;
                reg_rdata[C_TOMEM] = ctrl.to_mem;
                reg_rdata[C_HOLD]  = ctrl.hold;
                reg_rdata[C_FLAG0] = ctrl.flag_in_addr;
            end
            SEL_STAT: begin
                reg_rdata[S_ACT] = busy;
                reg_rdata[S_END] = st_end;
                reg_rdata[S_ERR] = st_err;
                reg_rdata[S_DEV] = st_dev;
            end
            SEL_BASE: reg_rdata = base;
            default:  reg_rdata = '0;
        endcase
    end

    // R7: a stop write always leaves start cleared
    p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && reg_wdata[C_STOP]) |=> !ctrl.go);

    // R8: hold and start never coexist
    p_hold_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl.hold |-> !ctrl.go);

    // R4: normal end appears together with start being released
    p_end_releases_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(st_end) |-> !ctrl.go);

    // R6: an error never comes with a normal end
    p_err_no_end_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(st_err) |-> (!ctrl.go && !$rose(st_end)));

    // R9: write-one clears normal end when no new end arrives
    p_w1c_end_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && reg_wdata[S_END] && !ev_end) |=> !st_end);

endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
    import sgdma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl,
    input  logic               kill,
    input  logic [ADDR_W-1:0]  base,
    output logic               busy,
    output logic               ev_end,
    output logic               ev_err,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [BE_W-1:0]    mem_be,
    input  logic               mem_ready,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data
);

    wstate_t            state, nstate;
    logic [ADDR_W-1:0]  tptr, cur;
    logic [DATA_W-1:0]  w0_q, hold_q;
    logic [LEN_W-1:0]   rem;
    logic               last_q, to_mem_q, flag_q;
    logic               abort, launch, seg_step, seg_last;
    desc_t              dsc;

    assign abort    = kill || !ctrl.go;
    assign launch   = (state == W_IDLE) && ctrl.go && !kill;
    assign seg_last = (rem <= WORD_BYTES);
    assign dsc      = decode_desc(w0_q, mem_rdata, flag_q);
    assign busy     = (state != W_IDLE);
    assign out_data = hold_q;

    always_comb begin
        nstate    = state;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = tptr;
        mem_wdata = in_data;
        mem_be    = '1;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        ev_end    = 1'b0;
        ev_err    = 1'b0;
        seg_step  = 1'b0;
        case (state)
            W_IDLE: if (launch) nstate = W_FETCH_A;
            W_FETCH_A: begin
                mem_req = !abort;
                if (!abort && mem_ready) nstate = W_FETCH_L;
            end
            W_FETCH_L: begin
                mem_req  = !abort;
                mem_addr = tptr + ADDR_W'(BE_W);
                if (!abort && mem_ready) begin
                    if (dsc.len > SEG_MAX) begin
                        ev_err = 1'b1;
                        nstate = W_IDLE;
                    end else if (dsc.len == '0) begin
                        if (dsc.last) begin
                            ev_end = 1'b1;
                            nstate = W_IDLE;
                        end else begin
                            nstate = W_FETCH_A;
                        end
                    end else begin
                        nstate = W_MOVE;
                    end
                end
            end
            W_MOVE: begin
                mem_addr = cur;
                if (to_mem_q) begin
                    mem_req  = in_valid && !abort;
                    mem_we   = 1'b1;
                    mem_be   = lane_mask(rem);
                    in_ready = mem_ready && !abort;
                    seg_step = in_valid && mem_ready && !abort;
                end else begin
                    mem_req = !abort;
                    if (!abort && mem_ready) nstate = W_PUSH;
                end
            end
            W_PUSH: begin
                out_valid = !abort;
                seg_step  = out_ready && !abort;
            end
            default: nstate = W_IDLE;
        endcase
        if (seg_step) begin
            if (!seg_last) begin
                nstate = W_MOVE;
            end else if (last_q) begin
                ev_end = 1'b1;
                nstate = W_IDLE;
            end else begin
                nstate = W_FETCH_A;
            end
        end
        if (abort && state != W_IDLE) nstate = W_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= W_IDLE;
            tptr     <= '0;
            cur      <= '0;
            w0_q     <= '0;
            hold_q   <= '0;
            rem      <= '0;
            last_q   <= 1'b0;
            to_mem_q <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            state <= nstate;
            if (launch) begin
                tptr     <= base;
                to_mem_q <= ctrl.to_mem;
                flag_q   <= ctrl.flag_in_addr;
            end
            if (state == W_FETCH_A && mem_ready && !abort)
                w0_q <= mem_rdata;
            if (state == W_FETCH_L && mem_ready && !abort) begin
                tptr   <= tptr + ADDR_W'(2 * BE_W);
                cur    <= dsc.addr;
                rem    <= dsc.len;
                last_q <= dsc.last;
            end
            if (state == W_MOVE && !to_mem_q && mem_ready && !abort)
                hold_q <= mem_rdata;
            if (seg_step) begin
                cur <= cur + ADDR_W'(BE_W);
                rem <= seg_last ? '0 : rem - WORD_BYTES;
            end
        end
    end

    // R3: streams follow the latched direction
    p_in_dir_r3: assert property (@(posedge clk) disable iff (rst)
        !to_mem_q |-> !in_ready);
    p_out_dir_r3: assert property (@(posedge clk) disable iff (rst)
        to_mem_q |-> !out_valid);

    // R6: a segment being moved is never empty nor over the limit
    p_seg_len_r6: assert property (@(posedge clk) disable iff (rst)
        (state == W_MOVE) |-> (rem != '0 && rem <= SEG_MAX));

    // R1: a stalled read keeps its address until taken or aborted
    p_read_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && !mem_ready) |=>
            ((mem_req && $stable(mem_addr)) || kill || !ctrl.go));

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int REG_AW = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                dev_irq,
    output logic                mem_req,
    output logic                mem_we,
    output logic [31:0]         mem_addr,
    output logic [31:0]         mem_wdata,
    output logic [3:0]          mem_be,
    input  logic                mem_ready,
    input  logic [31:0]         mem_rdata,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [31:0]         in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [31:0]         out_data
);

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] base;
    logic              kill, busy, ev_end, ev_err;

    sgdma_regs #(.REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dev_irq   (dev_irq),
        .busy      (busy),
        .ev_end    (ev_end),
        .ev_err    (ev_err),
        .ctrl      (ctrl),
        .base      (base),
        .kill      (kill)
    );

    sgdma_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .kill      (kill),
        .base      (base),
        .busy      (busy),
        .ev_end    (ev_end),
        .ev_err    (ev_err),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // R11: nothing is requested while the engine is idle and not launching
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy) |-> !mem_req);

endmodule

// File: tb/sim_sgdma_engine.sv
module sim_sgdma_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_irq = 1'b0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    always #4 clk = ~clk;   // 125 MHz

    sgdma_engine u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_irq(dev_irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    // memory model
    logic [31:0] mem [0:1023];
    logic        rdy_pat = 1'b0;
    assign mem_ready = mem_req && rdy_pat;
    assign mem_rdata = mem[mem_addr[11:2]];

    // scoreboard state
    logic [31:0] exp_out[$];
    logic [67:0] exp_wr[$];
    logic [31:0] src_q[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int hits   = 0;
    int out_cnt = 0;
    int watch_lo = 0, watch_hi = -1;
    logic out_en = 1'b0;
    logic pop_pend = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [67:0] act,
                       input logic [67:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // driver of stream and ready patterns
    always begin
        @(posedge clk);
        #1;
        cyc++;
        if (pop_pend && src_q.size() > 0) void'(src_q.pop_front());
        pop_pend  = 1'b0;
        in_valid  = (src_q.size() > 0);
        in_data   = (src_q.size() > 0) ? src_q[0] : 32'h0;
        rdy_pat   = (cyc % 3) != 2;
        out_ready = out_en && ((cyc % 4) != 1);
    end

    // monitor: pops expected items as the design produces them
    always begin
        @(negedge clk);
        if (!rst) begin
            if (in_valid && in_ready) pop_pend = 1'b1;
            if (mem_req && mem_ready && int'(mem_addr) >= watch_lo && int'(mem_addr) <= watch_hi)
                hits++;
            if (out_valid && out_ready) begin
                out_cnt++;
                if (exp_out.size() == 0)
                    chk(1'b0, "R1 unexpected output word", {36'h0, out_data}, 68'h0);
                else begin
                    logic [31:0] e;
                    e = exp_out.pop_front();
                    chk(out_data == e, "R1 output word", {36'h0, out_data}, {36'h0, e});
                end
            end
            if (mem_req && mem_we && mem_ready) begin
                logic [67:0] got;
                got = {mem_addr, mem_wdata, mem_be};
                if (exp_wr.size() == 0)
                    chk(1'b0, "R3 unexpected write", got, 68'h0);
                else begin
                    logic [67:0] e;
                    e = exp_wr.pop_front();
                    chk(got == e, "R3 memory write", got, e);
                end
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] = mem_wdata[8*b +: 8];
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd1, s);
            if (!s[0]) break;
        end
    endtask

    task automatic put_desc(input int idx, input logic [31:0] w0, input logic [31:0] w1);
        mem[(32'h100 + idx * 8) >> 2]       = w0;
        mem[((32'h100 + idx * 8) >> 2) + 1] = w1;
    endtask

    logic [31:0] v;
    int snap;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h0101_0103) ^ 32'hA500_0000;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R11 reset state
        rd(2'd0, v); chk(v == 0, "R11 control after reset", {36'h0, v}, 68'h0);
        rd(2'd1, v); chk(v == 0, "R11 status after reset", {36'h0, v}, 68'h0);
        rd(2'd2, v); chk(v == 0, "R11 base after reset", {36'h0, v}, 68'h0);
        chk(mem_req == 1'b0, "R11 no request after reset", {67'h0, mem_req}, 68'h0);

        // R1 base register keeps bits 31:3
        wr(2'd2, 32'h0000_0107);
        rd(2'd2, v); chk(v == 32'h100, "R1 base readback", {36'h0, v}, 68'h100);

        // R1/R2/R4: memory to device, flag in address word, 8 + 5 bytes
        put_desc(0, 32'h400, 32'd8);
        put_desc(1, 32'h501, 32'd5);
        exp_out.push_back(mem[32'h400 >> 2]);
        exp_out.push_back(mem[32'h404 >> 2]);
        exp_out.push_back(mem[32'h500 >> 2]);
        exp_out.push_back(mem[32'h504 >> 2]);
        out_en = 1'b1;
        wr(2'd0, 32'h801);
        wait_idle();
        chk(exp_out.size() == 0, "R1 all words delivered", exp_out.size(), 68'h0);
        rd(2'd1, v); chk(v == 32'h2, "R4 normal end status", {36'h0, v}, 68'h2);
        rd(2'd0, v); chk(v == 32'h800, "R4 start released", {36'h0, v}, 68'h800);

        // R9 write-zero keeps, write-one clears
        wr(2'd1, 32'h0);
        rd(2'd1, v); chk(v == 32'h2, "R9 write zero keeps end", {36'h0, v}, 68'h2);
        wr(2'd1, 32'h3);
        rd(2'd1, v); chk(v == 32'h0, "R9 write one clears end", {36'h0, v}, 68'h0);

        // R3 device to memory, 6 bytes: second word low two lanes only
        mem[32'h600 >> 2] = 32'hFFFF_FFFF;
        mem[32'h604 >> 2] = 32'hFFFF_FFFF;
        put_desc(0, 32'h601, 32'd6);
        exp_wr.push_back({32'h600, 32'h1234_5678, 4'hF});
        exp_wr.push_back({32'h604, 32'h9ABC_DEF0, 4'h3});
        src_q.push_back(32'h1234_5678);
        src_q.push_back(32'h9ABC_DEF0);
        wr(2'd0, 32'h805);
        wait_idle();
        chk(exp_wr.size() == 0, "R3 all writes seen", exp_wr.size(), 68'h0);
        chk(mem[32'h604 >> 2] == 32'hFFFF_DEF0, "R3 partial word lanes",
            {36'h0, mem[32'h604 >> 2]}, {36'h0, 32'hFFFF_DEF0});
        rd(2'd1, v); chk(v == 32'h2, "R4 end after write walk", {36'h0, v}, 68'h2);
        wr(2'd1, 32'h2);

        // R5 zero-length descriptor skipped, then a normal one
        watch_lo = 32'h700; watch_hi = 32'h7FF; hits = 0;
        put_desc(0, 32'h700, 32'd0);
        put_desc(1, 32'h401, 32'd4);
        exp_out.push_back(mem[32'h400 >> 2]);
        wr(2'd0, 32'h801);
        wait_idle();
        chk(hits == 0, "R5 no access to empty buffer", hits, 68'h0);
        chk(exp_out.size() == 0, "R5 walk continued past empty", exp_out.size(), 68'h0);
        rd(2'd1, v); chk(v == 32'h2, "R5 end after skip", {36'h0, v}, 68'h2);
        wr(2'd1, 32'h2);

        // R5 zero-length descriptor carrying the end mark
        put_desc(0, 32'h701, 32'd0);
        wr(2'd0, 32'h801);
        wait_idle();
        chk(hits == 0, "R5 no access for empty last", hits, 68'h0);
        rd(2'd1, v); chk(v == 32'h2, "R5 empty last ends normally", {36'h0, v}, 68'h2);
        wr(2'd1, 32'h2);
        watch_lo = 0; watch_hi = -1;

        // R2 flag in length bit 31 when control bit 11 is clear
        put_desc(0, 32'h401, 32'd4);
        put_desc(1, 32'h500, 32'h8000_0004);
        exp_out.push_back(mem[32'h400 >> 2]);
        exp_out.push_back(mem[32'h500 >> 2]);
        wr(2'd0, 32'h001);
        wait_idle();
        chk(exp_out.size() == 0, "R2 length-word flag decode", exp_out.size(), 68'h0);
        rd(2'd1, v); chk(v == 32'h2, "R2 end via length flag", {36'h0, v}, 68'h2);
        wr(2'd1, 32'h2);

        // R6 over-long segment
        snap = out_cnt;
        put_desc(0, 32'h401, 32'h1FFF_FFFF);
        wr(2'd0, 32'h801);
        wait_idle();
        rd(2'd1, v); chk(v == 32'h4, "R6 error status", {36'h0, v}, 68'h4);
        chk(out_cnt == snap, "R6 no data on error", out_cnt, snap);
        rd(2'd0, v); chk(v == 32'h800, "R6 start cleared on error", {36'h0, v}, 68'h800);
        wr(2'd1, 32'h4);

        // R6 limit accepted, R7 stop terminates at once
        out_en = 1'b0;
        put_desc(0, 32'h401, 32'h1FFF_FFFE);
        wr(2'd0, 32'h801);
        repeat (20) @(posedge clk);
        rd(2'd1, v); chk(v == 32'h1, "R6 limit length runs", {36'h0, v}, 68'h1);
        snap = out_cnt;
        wr(2'd0, 32'h802);
        rd(2'd1, v); chk(v == 32'h0, "R7 stop drops active", {36'h0, v}, 68'h0);
        rd(2'd0, v); chk(v == 32'h800, "R7 stop clears start", {36'h0, v}, 68'h800);
        out_en = 1'b1;
        repeat (10) @(posedge clk);
        chk(out_cnt == snap, "R7 no handshake after stop", out_cnt, snap);

        // R8 hold blocks start, and aborts a running walk
        wr(2'd0, 32'h081);
        rd(2'd0, v); chk(v == 32'h080, "R8 start ignored under hold", {36'h0, v}, 68'h80);
        rd(2'd1, v); chk(v == 32'h0, "R8 idle under hold", {36'h0, v}, 68'h0);
        wr(2'd0, 32'h000);
        out_en = 1'b0;
        wr(2'd0, 32'h801);
        repeat (10) @(posedge clk);
        wr(2'd0, 32'h880);
        rd(2'd1, v); chk(v == 32'h0, "R8 hold aborts walk", {36'h0, v}, 68'h0);
        wr(2'd0, 32'h800);

        // R10 device interrupt, R9 clears
        @(posedge clk); #1 dev_irq = 1'b1;
        @(posedge clk); #1 dev_irq = 1'b0;
        rd(2'd1, v); chk(v == 32'h10, "R10 device event latched", {36'h0, v}, 68'h10);
        wr(2'd1, 32'h0);
        rd(2'd1, v); chk(v == 32'h10, "R9 zero write keeps device bit", {36'h0, v}, 68'h10);
        wr(2'd1, 32'h11);
        rd(2'd1, v); chk(v == 32'h0, "R9 one write clears device bit", {36'h0, v}, 68'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule